// File: doc/BRIEF.md
# Paged Buffer Address Translator with Byte-Lane Swap

This block sits between a network controller and a buffer RAM on the same board. The controller issues 24-bit addresses. The block looks each address up in a page map that the host writes. From the map entry it forms the physical RAM address, a byte-order flag and a flag that says which memory holds the page. The same lookup serves host accesses to the RAM, so both sides see one layout.

Each map entry is 16 bits wide. Bits 11:0 hold the physical frame number, bit 13 selects memory on the secondary backplane connector, and bit 15 selects host (big-endian) byte order. When an entry leaves bit 15 clear, the page uses controller (little-endian) order, and the block exchanges the two byte lanes of data and byte enables on the way into and out of RAM. A frame beyond the on-board RAM is flagged and the access is suppressed.

The requester marks an access with the translate valid input. It gives the address, the byte enables and the write data in host lane order. One clock later the block presents the physical address, the flags, a RAM enable, and the lane-adjusted write data and byte enables. Read data coming back from RAM is lane-adjusted combinationally, using the order of the access currently held in the output stage.

Top module: `pagemap_xlat`

## Requirements
- R1: Controller address bits 23:20 have no effect; bits 19:10 select the map entry and bits 9:0 pass through unchanged as bits 9:0 of `phys_addr`.
- R2: One clock after an access is presented, `phys_addr` equals the selected entry's bits 11:0 followed by the 10-bit offset.
- R3: `host_order` equals bit 15 of the selected entry, registered with the access.
- R4: `off_board` equals bit 13 of the selected entry, registered with the access.
- R5: When `off_board` is 0 and the frame number is 256 or more, `out_range` is 1 and `ram_en` is 0. An off-board page never sets `out_range`, whatever its frame number.
- R6: When the entry selects little-endian order, `ram_wdata` carries the two bytes of `xl_wdata` exchanged and `ram_be` carries the two enable bits of `xl_be` exchanged. Under host order both pass unchanged. An 8-bit access (one enable bit set) therefore moves to the opposite lane.
- R7: `xl_rdata` equals `ram_rdata` with its bytes exchanged when the registered `host_order` is 0, and equals `ram_rdata` unchanged when it is 1.
- R8: After a synchronous active-low reset, every map entry reads 0, and `out_valid`, `ram_en`, `out_range` and `phys_addr` are 0.
- R9: A map write takes effect for translations presented from the next clock cycle onward. A translation presented in the same cycle as the write uses the old entry.
- R10: `map_rdata` shows, one clock later, the entry addressed by `map_idx`; on a same-cycle write it shows the previous contents.
- R11: When `xl_valid` is 0, the next cycle has `out_valid` and `ram_en` both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_idx | input | 10 | Host map entry index |
| map_we | input | 1 | Host map write strobe |
| map_wdata | input | 16 | Host map write data |
| map_rdata | output | 16 | Registered host map read data |
| xl_valid | input | 1 | Access present |
| xl_addr | input | 24 | Controller address |
| xl_be | input | 2 | Byte enables, host lane order |
| xl_wdata | input | 16 | Write data, host lane order |
| xl_rdata | output | 16 | Read data returned to requester, host lane order |
| out_valid | output | 1 | Registered access valid |
| phys_addr | output | 22 | Physical RAM address |
| host_order | output | 1 | Page uses host byte order |
| off_board | output | 1 | Page is in backplane memory |
| out_range | output | 1 | On-board frame beyond RAM size |
| ram_en | output | 1 | RAM access enable |
| ram_be | output | 2 | Lane-adjusted byte enables |
| ram_wdata | output | 16 | Lane-adjusted write data |
| ram_rdata | input | 16 | Raw data from RAM |

## Verification
Every translation result, and the host map read data, is due exactly one clock edge after its inputs. `xl_rdata` is combinational on `ram_rdata` and on the registered order flag. The bench drives inputs on the falling edge and computes the expected values at that moment from its own copy of the map, taken before that cycle's write is applied. It then compares them at the following falling edge, which covers both the same-cycle write rule and the next-cycle rule. Read data is driven together with the access and checked at that same falling edge, against the order flag expected for the access then held in the output stage.

// File: rtl/pagemap_pkg.sv
// Package: shared geometry and entry field positions for the page-map translator.
// Assumes a 24-bit requester address, 1 KiB pages and 16-bit map entries.
package pagemap_pkg;
    localparam int ADDR_W    = 24;
    localparam int IDX_W     = 10;
    localparam int OFF_W     = 10;
    localparam int ENTRY_W   = 16;
    localparam int FRAME_W   = 12;
    localparam int PHYS_W    = FRAME_W + OFF_W;
    localparam int RAM_PAGES = 256;
    localparam int LANES     = 2;
    localparam int DATA_W    = 8 * LANES;
    localparam int ORDER_BIT = 15;
    localparam int PLACE_BIT = 13;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               host_order;
        logic               off_board;
    } pte_fields_t;

    // Split a raw entry into its decoded fields.
    function automatic pte_fields_t decode_pte(input logic [ENTRY_W-1:0] e);
        pte_fields_t f;
        f.frame      = e[FRAME_W-1:0];
        f.host_order = e[ORDER_BIT];
        f.off_board  = e[PLACE_BIT];
        return f;
    endfunction
endpackage

// File: rtl/pagemap_store.sv
// Module: pagemap_store
// Holds the page map. It gives a registered read port to the host and a
// combinational lookup port to the translator. Assumes a single writer
// (the host); a write lands at the clock edge, so lookups see it from the
// next cycle on.
module pagemap_store
    import pagemap_pkg::*;
#(
    parameter int N_ENTRIES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   host_idx,
    input  logic               host_we,
    input  logic [ENTRY_W-1:0] host_wdata,
    output logic [ENTRY_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]   look_idx,
    output logic [ENTRY_W-1:0] look_entry
);
    logic [ENTRY_W-1:0] mem_q [N_ENTRIES];

    // Map array: clear on reset, host write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) mem_q[i] <= '0;
        end else if (host_we) begin
            mem_q[host_idx] <= host_wdata;
        end
    end

    // Host read register: returns the pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n) host_rdata <= '0;
        else        host_rdata <= mem_q[host_idx];
    end

    // Translator lookup, combinational.
    always_comb look_entry = mem_q[look_idx];

    AST_RDATA_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> host_rdata == '0); // R8
endmodule

// File: rtl/lane_swap.sv
// Module: lane_swap
// Reverses byte lanes of a data word and its enables when swap_en is set,
// and passes them through otherwise. Purely combinational.
module lane_swap #(
    parameter int N_LANES = 2,
    localparam int W = 8 * N_LANES
) (
    input  logic               swap_en,
    input  logic [W-1:0]       din,
    input  logic [N_LANES-1:0] be_in,
    output logic [W-1:0]       dout,
    output logic [N_LANES-1:0] be_out
);
    logic [W-1:0]       rev_d;
    logic [N_LANES-1:0] rev_b;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign rev_d[8*g +: 8] = din[8*(N_LANES-1-g) +: 8];
        assign rev_b[g]        = be_in[N_LANES-1-g];
    end

    // Choose reversed or straight lanes.
    always_comb begin
        dout   = swap_en ? rev_d : din;
        be_out = swap_en ? rev_b : be_in;
    end
endmodule

// File: rtl/pagemap_xlate.sv
// Module: pagemap_xlate
// Registers one translation per cycle. It forms the physical address from
// the entry's frame and the page offset, carries the order and placement
// flags, flags on-board frames beyond the RAM, and registers the
// lane-adjusted write data. Assumes the entry is valid in the same cycle as
// the address.
module pagemap_xlate
    import pagemap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [ENTRY_W-1:0] in_entry,
    input  logic [LANES-1:0]   in_be,
    input  logic [DATA_W-1:0]  in_wdata,
    output logic [IDX_W-1:0]   look_idx,
    output logic               q_valid,
    output logic [PHYS_W-1:0]  q_phys,
    output logic               q_host_order,
    output logic               q_off_board,
    output logic               q_range,
    output logic               q_ram_en,
    output logic [LANES-1:0]   q_be,
    output logic [DATA_W-1:0]  q_wdata
);
    pte_fields_t        f;
    logic               bad_frame;
    logic [DATA_W-1:0]  sw_data;
    logic [LANES-1:0]   sw_be;

    // Index from the middle address bits; the top nibble is dropped.
    always_comb look_idx = in_addr[OFF_W +: IDX_W];

    // Decode the entry and test the frame against the on-board RAM size.
    always_comb begin
        f         = decode_pte(in_entry);
        bad_frame = !f.off_board && (f.frame >= FRAME_W'(RAM_PAGES));
    end

    lane_swap #(.N_LANES(LANES)) u_wswap (
        .swap_en (!f.host_order),
        .din     (in_wdata),
        .be_in   (in_be),
        .dout    (sw_data),
        .be_out  (sw_be)
    );

    // Output stage: one register per result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid      <= 1'b0;
            q_phys       <= '0;
            q_host_order <= 1'b0;
            q_off_board  <= 1'b0;
            q_range      <= 1'b0;
            q_ram_en     <= 1'b0;
            q_be         <= '0;
            q_wdata      <= '0;
        end else begin
            q_valid      <= in_valid;
            q_phys       <= {f.frame, in_addr[OFF_W-1:0]};
            q_host_order <= f.host_order;
            q_off_board  <= f.off_board;
            q_range      <= in_valid && bad_frame;
            q_ram_en     <= in_valid && !bad_frame;
            q_be         <= sw_be;
            q_wdata      <= sw_data;
        end
    end

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && q_valid |-> q_phys[OFF_W-1:0] == $past(in_addr[OFF_W-1:0])); // R1
    AST_RANGE_ONBOARD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        q_range |-> !q_off_board && (q_phys[PHYS_W-1:OFF_W+8] != '0) && !q_ram_en); // R5
    AST_BE_COUNT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && q_valid |-> $countones(q_be) == $countones($past(in_be))); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(in_valid) |-> !q_valid && !q_ram_en); // R11
endmodule

// File: rtl/pagemap_xlat.sv
// Module: pagemap_xlat (top)
// Page-map address translator with byte-lane swapping. It ties the map
// store to the translator, and lane-adjusts returning read data using the
// order of the access held in the output stage. Assumes RAM read data
// arrives while that access is still held.
module pagemap_xlat
    import pagemap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    map_idx,
    input  logic                map_we,
    input  logic [ENTRY_W-1:0]  map_wdata,
    output logic [ENTRY_W-1:0]  map_rdata,
    input  logic                xl_valid,
    input  logic [ADDR_W-1:0]   xl_addr,
    input  logic [LANES-1:0]    xl_be,
    input  logic [DATA_W-1:0]   xl_wdata,
    output logic [DATA_W-1:0]   xl_rdata,
    output logic                out_valid,
    output logic [PHYS_W-1:0]   phys_addr,
    output logic                host_order,
    output logic                off_board,
    output logic                out_range,
    output logic                ram_en,
    output logic [LANES-1:0]    ram_be,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata
);
    logic [IDX_W-1:0]   look_idx;
    logic [ENTRY_W-1:0] look_entry;
    logic [LANES-1:0]   rd_be_unused;

    pagemap_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_idx   (map_idx),
        .host_we    (map_we),
        .host_wdata (map_wdata),
        .host_rdata (map_rdata),
        .look_idx   (look_idx),
        .look_entry (look_entry)
    );

    pagemap_xlate u_xlate (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (xl_valid),
        .in_addr      (xl_addr),
        .in_entry     (look_entry),
        .in_be        (xl_be),
        .in_wdata     (xl_wdata),
        .look_idx     (look_idx),
        .q_valid      (out_valid),
        .q_phys       (phys_addr),
        .q_host_order (host_order),
        .q_off_board  (off_board),
        .q_range      (out_range),
        .q_ram_en     (ram_en),
        .q_be         (ram_be),
        .q_wdata      (ram_wdata)
    );

    lane_swap #(.N_LANES(LANES)) u_rswap (
        .swap_en (!host_order),
        .din     (ram_rdata),
        .be_in   ({LANES{1'b1}}),
        .dout    (xl_rdata),
        .be_out  (rd_be_unused)
    );

    AST_RDATA_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_rdata[7:0] == ram_rdata[7:0]) || (xl_rdata[7:0] == ram_rdata[15:8])); // R7
endmodule

// File: tb/tb_pagemap_xlat.sv
module tb_pagemap_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  map_idx = '0;
    logic        map_we = 1'b0;
    logic [15:0] map_wdata = '0;
    logic [15:0] map_rdata;
    logic        xl_valid = 1'b0;
    logic [23:0] xl_addr = '0;
    logic [1:0]  xl_be = '0;
    logic [15:0] xl_wdata = '0;
    logic [15:0] xl_rdata;
    logic        out_valid;
    logic [21:0] phys_addr;
    logic        host_order, off_board, out_range, ram_en;
    logic [1:0]  ram_be;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;

    int total = 0;
    int bad = 0;
    logic [15:0] mdl [1024];

    // Expected values for the access currently in flight.
    logic [15:0] e_rdata;
    logic        e_valid, e_order, e_off, e_range, e_en;
    logic [21:0] e_phys;
    logic [1:0]  e_be;
    logic [15:0] e_wdata;

    always #4 clk = ~clk;

    pagemap_xlat dut (.*);

    function automatic logic [15:0] swap16(input logic [15:0] d);
        return {d[7:0], d[15:8]};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Compute the expected results for the inputs now driven, then apply the write to the model.
    task automatic predict();
        logic [15:0] ent;
        logic [11:0] fr;
        ent     = mdl[xl_addr[19:10]];
        fr      = ent[11:0];
        e_rdata = mdl[map_idx];
        e_valid = xl_valid;
        e_phys  = {fr, xl_addr[9:0]};
        e_order = ent[15];
        e_off   = ent[13];
        e_range = xl_valid && !ent[13] && (fr >= 12'd256);
        e_en    = xl_valid && !e_range;
        e_be    = ent[15] ? xl_be : {xl_be[0], xl_be[1]};
        e_wdata = ent[15] ? xl_wdata : swap16(xl_wdata);
        if (map_we) mdl[map_idx] = map_wdata;
    endtask

    task automatic check_all();
        chk("R10", "map_rdata", 32'(map_rdata), 32'(e_rdata));
        chk("R11", "out_valid", 32'(out_valid), 32'(e_valid));
        chk("R2",  "phys_addr", 32'(phys_addr), 32'(e_phys));
        chk("R3",  "host_order", 32'(host_order), 32'(e_order));
        chk("R4",  "off_board", 32'(off_board), 32'(e_off));
        chk("R5",  "out_range", 32'(out_range), 32'(e_range));
        chk("R5",  "ram_en", 32'(ram_en), 32'(e_en));
        chk("R6",  "ram_be", 32'(ram_be), 32'(e_be));
        chk("R6",  "ram_wdata", 32'(ram_wdata), 32'(e_wdata));
        chk("R7",  "xl_rdata", 32'(xl_rdata), 32'(e_order ? ram_rdata : swap16(ram_rdata)));
    endtask

    // One cycle: drive at negedge, check at the next negedge.
    task automatic step(input logic we, input logic [9:0] idx, input logic [15:0] wd,
                        input logic v, input logic [23:0] a, input logic [1:0] be,
                        input logic [15:0] d, input logic [15:0] rd);
        map_we = we; map_idx = idx; map_wdata = wd;
        xl_valid = v; xl_addr = a; xl_be = be; xl_wdata = d; ram_rdata = rd;
        predict();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #1000000;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R8: reset state of outputs.
        chk("R8", "out_valid", 32'(out_valid), 0);
        chk("R8", "ram_en", 32'(ram_en), 0);
        chk("R8", "out_range", 32'(out_range), 0);
        chk("R8", "phys_addr", 32'(phys_addr), 0);
        chk("R8", "map_rdata", 32'(map_rdata), 0);
        rst_n = 1'b1;
        // R8: an entry reads zero after reset.
        step(0, 10'd1023, 0, 0, 0, 2'b11, 0, 0);
        chk("R8", "entry1023", 32'(map_rdata), 0);
        // R9: a translation in the write cycle uses the old entry, the next one the new entry.
        step(1, 10'd1023, 16'h8000 | 16'd5, 1, 24'hFFFFF4, 2'b11, 16'hA1B2, 16'h1234);
        step(0, 10'd1023, 0, 1, 24'hFFFFF4, 2'b11, 16'hA1B2, 16'h1234);
        chk("R9", "new frame used", 32'(phys_addr), 32'({12'd5, 10'h3F4}));
        // R1: top nibble ignored, aliasing to the same entry.
        step(0, 10'd0, 0, 1, 24'h0FFFF4, 2'b11, 16'h0001, 16'h0002);
        chk("R1", "alias", 32'(phys_addr), 32'({12'd5, 10'h3F4}));
        // R6: 8-bit lane exchange under controller order (entry 3 = frame 7, order 0).
        step(1, 10'd3, 16'd7, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, {4'h0, 10'd3, 10'd1}, 2'b01, 16'h00CD, 16'hBEEF);
        chk("R6", "lane moved", 32'(ram_be), 32'(2'b10));
        // R5: on-board frame 256 out of range; off-board frame 4095 accepted.
        step(1, 10'd4, 16'd256, 0, 0, 0, 0, 0);
        step(1, 10'd5, 16'h2FFF, 1, {4'h0, 10'd4, 10'd0}, 2'b11, 0, 0);
        chk("R5", "range at 256", 32'(out_range), 1);
        step(0, 0, 0, 1, {4'h0, 10'd5, 10'd0}, 2'b11, 0, 0);
        chk("R5", "off-board no range", 32'(ram_en), 1);
        // Random traffic, biased onto a small set of entries.
        for (int n = 0; n < 3000; n++) begin
            logic [9:0] wi, li;
            logic [15:0] ent;
            wi  = ($urandom % 4 == 0) ? 10'($urandom) : 10'($urandom % 8);
            li  = ($urandom % 4 == 0) ? 10'($urandom) : 10'($urandom % 8);
            ent = 16'($urandom);
            if ($urandom % 2 == 0) ent[11:8] = 4'h0;
            step($urandom % 3 == 0, wi, ent, $urandom % 4 != 0,
                 {4'($urandom), li, 10'($urandom)}, 2'($urandom),
                 16'($urandom), 16'($urandom));
        end
        finish_run();
    end
endmodule